// File: doc/BRIEF.md
# Two-Tier Priority Interrupt Arbiter

This block watches up to 54 interrupt request lines and, on every clock, names the one pending request that should be serviced next. Each source has an enable bit and a 3-bit level that software programs through a small synchronous register port. The choice is made in two tiers. The highest programmed level wins first. Among requests that share that level, the source with the lowest index wins.

The result is registered. It gives the winning source index, its vector number (index plus 8) and its level, with a valid flag. A current-level input acts as a threshold: only requests whose level is strictly above it take part. Level 0 is never selected. Some source positions are reserved at elaboration time and can never win.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every source level reads 4, every enable bit reads 0, `cfg_rdata` is 0 and all winner outputs are 0 with `win_valid` low.
- R2: Level word w (address 0 to 13) holds source 4w+n in bits [4n+2:4n]. Bit 4n+3 ignores writes and reads 0. Nibbles for sources above 53 read 0.
- R3: Enable word k (address 16+k, k 0 to 3) holds the enable of source 16k+b in bit b. Bits for sources above 53 and for reserved sources ignore writes and read 0.
- R4: A read returns, on the cycle after the address is presented, the register contents from before any write in that same cycle. Addresses 14, 15 and 20 to 31 read 0.
- R5: A source programmed with level 0 is never selected.
- R6: A source takes part only when its level is strictly greater than `cur_lvl`.
- R7: Among eligible requests, the highest programmed level wins regardless of source index.
- R8: Among eligible requests at the same highest level, the lowest source index wins.
- R9: `win_vec` equals `win_src` plus 8 whenever `win_valid` is high.
- R10: Reserved sources 41 and 45 to 53 never win, whatever their request or level.
- R11: The winner outputs reflect the requests, `cur_lvl` and register state present one clock earlier. With no eligible request, `win_valid` is low and `win_src`, `win_vec` and `win_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 54 | Request lines, bit i for source i |
| cur_lvl | input | 3 | Threshold; only levels above it are eligible |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for the previous cycle's address |
| win_valid | output | 1 | A winner is presented |
| win_src | output | 6 | Winning source index |
| win_vec | output | 6 | Winning vector number |
| win_lvl | output | 3 | Level of the winner |

## Verification
The arbitration is exercised with single requests, which confirm the index-to-vector mapping, and with distinct levels across many sources, which show level ranking. Equal levels across scattered sources isolate the index tie-break. A low-index source at a low level against a high-index source at level 7 shows that level overrides index. Requests only on level-0 sources, a sweep of `cur_lvl` over one fixed pattern, and high-level requests on reserved positions each separate one exclusion rule from the others. A long run of random requests, thresholds and register writes is then compared cycle by cycle against a behavioural model, which also covers write-then-arbitrate ordering across the one-cycle latency.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_SRC       = 54;
    localparam int LVL_W         = 3;
    localparam int NIB_W         = 4;
    localparam int REG_W         = 16;
    localparam int SRC_PER_REG   = REG_W / NIB_W;
    localparam int NUM_PRIO_REGS = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG;
    localparam int NUM_EN_REGS   = (NUM_SRC + REG_W - 1) / REG_W;
    localparam int EN_BASE       = 16;
    localparam int ADDR_W        = $clog2(EN_BASE + NUM_EN_REGS);
    localparam int SRC_W         = $clog2(NUM_SRC);
    localparam int LEAVES        = 1 << SRC_W;
    localparam int VEC_BASE      = 8;
    localparam int VEC_W         = $clog2(NUM_SRC + VEC_BASE);

    // Positions that can never win.
    localparam logic [NUM_SRC-1:0] DEF_RSVD_MASK = 54'h3F_E200_0000_0000;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [SRC_W-1:0] idx;
    } cand_t;

    // lo holds the lower source indices, so it keeps the tie.
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        cand_t r;
        if (lo.vld && (!hi.vld || lo.lvl >= hi.lvl))
            r = lo;
        else if (hi.vld)
            r = hi;
        else
            r = '0;
        return r;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter logic [LVL_W-1:0]   RESET_LVL = 3'd4,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = DEF_RSVD_MASK
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    output logic [REG_W-1:0]                rdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o,
    output logic [NUM_SRC-1:0]              en_o
);

    localparam int PAD_PRIO = NUM_PRIO_REGS * SRC_PER_REG;
    localparam int PAD_EN   = NUM_EN_REGS * REG_W;

    logic [PAD_PRIO-1:0][LVL_W-1:0] lvl_pad;
    logic [PAD_EN-1:0]              en_pad;
    logic [REG_W-1:0]               rd_next;

    for (genvar s = 0; s < PAD_PRIO; s++) begin : g_lvl
        if (s < NUM_SRC) begin : g_live
            logic [LVL_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= RESET_LVL;
                else if (wr_en && addr == ADDR_W'(s / SRC_PER_REG))
                    q <= wdata[(s % SRC_PER_REG) * NIB_W +: LVL_W];
            end
            assign lvl_pad[s] = q;
            assign lvl_o[s]   = q;
        end else begin : g_pad
            assign lvl_pad[s] = '0;
        end
    end

    for (genvar s = 0; s < PAD_EN; s++) begin : g_en
        if (s < NUM_SRC && !RSVD_MASK[s]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (wr_en && addr == ADDR_W'(EN_BASE + s / REG_W))
                    q <= wdata[s % REG_W];
            end
            assign en_pad[s] = q;
        end else begin : g_pad
            assign en_pad[s] = 1'b0;
        end
    end

    assign en_o = en_pad[NUM_SRC-1:0];

    always_comb begin
        rd_next = '0;
        for (int w = 0; w < NUM_PRIO_REGS; w++) begin
            if (addr == ADDR_W'(w)) begin
                for (int n = 0; n < SRC_PER_REG; n++)
                    rd_next[n*NIB_W +: LVL_W] = lvl_pad[w*SRC_PER_REG + n];
            end
        end
        for (int k = 0; k < NUM_EN_REGS; k++) begin
            if (addr == ADDR_W'(EN_BASE + k))
                rd_next = en_pad[k*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_next;
    end

endmodule

// File: rtl/irq_elig.sv
module irq_elig
    import irq_arb_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] RSVD_MASK = DEF_RSVD_MASK
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0]            en,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]              cur_lvl,
    output logic [NUM_SRC-1:0]            elig
);

    logic [NUM_SRC-1:0] above;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign above[s] = (lvl[s] != '0) && (lvl[s] > cur_lvl);
    end

    assign elig = req & en & above & ~RSVD_MASK;

endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    output cand_t                         win
);

    for (genvar st = 0; st <= SRC_W; st++) begin : g_st
        localparam int N = LEAVES >> st;
        cand_t nd [N];
        if (st == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_i
                if (i < NUM_SRC) begin : g_live
                    assign nd[i] = elig[i] ? cand_t'{vld: 1'b1, lvl: lvl[i], idx: SRC_W'(i)}
                                           : cand_t'('0);
                end else begin : g_pad
                    assign nd[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar i = 0; i < N; i++) begin : g_i
                assign nd[i] = pick(g_st[st-1].nd[2*i], g_st[st-1].nd[2*i+1]);
            end
        end
    end

    assign win = g_st[SRC_W].nd[0];

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter logic [LVL_W-1:0]   RESET_LVL = 3'd4,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = DEF_RSVD_MASK
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic [LVL_W-1:0]     cur_lvl,
    input  logic                 cfg_wr_en,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic                 win_valid,
    output logic [SRC_W-1:0]     win_src,
    output logic [VEC_W-1:0]     win_vec,
    output logic [LVL_W-1:0]     win_lvl
);

    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [NUM_SRC-1:0]            en;
    logic [NUM_SRC-1:0]            elig;
    cand_t                         best;

    irq_cfg_regs #(
        .RESET_LVL (RESET_LVL),
        .RSVD_MASK (RSVD_MASK)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .lvl_o (lvl),
        .en_o  (en)
    );

    irq_elig #(
        .RSVD_MASK (RSVD_MASK)
    ) u_elig (
        .req     (irq_req),
        .en      (en),
        .lvl     (lvl),
        .cur_lvl (cur_lvl),
        .elig    (elig)
    );

    irq_arb_tree u_tree (
        .elig (elig),
        .lvl  (lvl),
        .win  (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_src   <= '0;
            win_vec   <= '0;
            win_lvl   <= '0;
        end else begin
            win_valid <= best.vld;
            win_src   <= best.idx;
            win_lvl   <= best.lvl;
            win_vec   <= best.vld ? VEC_W'(best.idx) + VEC_W'(VEC_BASE) : '0;
        end
    end

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] RSVD_MASK = DEF_RSVD_MASK
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [LVL_W-1:0]   cur_lvl,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [REG_W-1:0]   cfg_rdata,
    input logic               win_valid,
    input logic [SRC_W-1:0]   win_src,
    input logic [VEC_W-1:0]   win_vec,
    input logic [LVL_W-1:0]   win_lvl
);

    logic [NUM_SRC-1:0] req_d;
    logic [LVL_W-1:0]   cur_d;
    logic               prio_rd_d;

    always_ff @(posedge clk) begin
        req_d     <= irq_req;
        cur_d     <= cur_lvl;
        prio_rd_d <= (cfg_addr < ADDR_W'(NUM_PRIO_REGS));
    end

    AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_vec == VEC_W'(win_src) + VEC_W'(VEC_BASE))); // R9

    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_lvl != '0)); // R5

    AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_lvl > cur_d)); // R6

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> !RSVD_MASK[win_src]); // R10

    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> req_d[win_src]); // R11

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (win_src == '0 && win_vec == '0 && win_lvl == '0)); // R11

    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        prio_rd_d |-> ((cfg_rdata & 16'h8888) == 16'h0000)); // R2

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .RSVD_MASK (RSVD_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .cur_lvl   (cur_lvl),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .win_valid (win_valid),
    .win_src   (win_src),
    .win_vec   (win_vec),
    .win_lvl   (win_lvl)
);

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [53:0] irq_req = '0;
    logic [2:0]  cur_lvl = '0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        win_valid;
    logic [5:0]  win_src;
    logic [5:0]  win_vec;
    logic [2:0]  win_lvl;

    int compared = 0;
    int mismatched = 0;
    string tag = "R1";

    int m_lvl [54];
    int m_en  [54];

    int e_valid, e_src, e_vec, e_lvl, e_rd;

    always #4 clk = ~clk;

    irq_prio_arbiter u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .cur_lvl   (cur_lvl),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_valid (win_valid),
        .win_src   (win_src),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    function automatic bit is_rsvd(input int i);
        return (i == 41) || (i >= 45);
    endfunction

    function automatic int model_read(input int a);
        int v = 0;
        if (a < 14) begin
            for (int n = 0; n < 4; n++) begin
                int s = 4 * a + n;
                if (s < 54) v = v | (m_lvl[s] << (4 * n));
            end
        end else if (a >= 16 && a < 20) begin
            for (int b = 0; b < 16; b++) begin
                int s = 16 * (a - 16) + b;
                if (s < 54 && !is_rsvd(s) && m_en[s] != 0) v = v | (1 << b);
            end
        end
        return v;
    endfunction

    task automatic model_write(input int a, input int d);
        if (a < 14) begin
            for (int n = 0; n < 4; n++) begin
                int s = 4 * a + n;
                if (s < 54) m_lvl[s] = (d >> (4 * n)) & 7;
            end
        end else if (a >= 16 && a < 20) begin
            for (int b = 0; b < 16; b++) begin
                int s = 16 * (a - 16) + b;
                if (s < 54 && !is_rsvd(s)) m_en[s] = (d >> b) & 1;
            end
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 54; i++) begin
            m_lvl[i] = 4;
            m_en[i]  = 0;
        end
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Called right after a falling edge; arbitrates on the next rising edge.
    task automatic step(input bit we, input int a, input int d);
        int best = -1;
        int bl = 0;
        cfg_wr_en = we;
        cfg_addr  = a[4:0];
        cfg_wdata = d[15:0];
        for (int i = 0; i < 54; i++) begin
            if (!is_rsvd(i) && irq_req[i] && m_en[i] != 0 && m_lvl[i] != 0 &&
                m_lvl[i] > int'(cur_lvl) && m_lvl[i] > bl) begin
                best = i;
                bl   = m_lvl[i];
            end
        end
        e_valid = (best >= 0) ? 1 : 0;
        e_src   = (best >= 0) ? best : 0;
        e_vec   = (best >= 0) ? best + 8 : 0;
        e_lvl   = (best >= 0) ? bl : 0;
        e_rd    = model_read(a);
        if (we) model_write(a, d);
        @(negedge clk);
        chk(tag, "valid", int'(win_valid), e_valid);
        chk(tag, "src", int'(win_src), e_src);
        chk(tag, "lvl", int'(win_lvl), e_lvl);
        chk("R9", "vector", int'(win_vec), e_vec);
        chk(tag, "rdata", int'(cfg_rdata), e_rd);
    endtask

    task automatic wr(input int a, input int d);
        step(1'b1, a, d);
    endtask

    task automatic rd(input int a);
        step(1'b0, a, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "valid in reset", int'(win_valid), 0);
        chk("R1", "src in reset", int'(win_src), 0);
        chk("R1", "rdata in reset", int'(cfg_rdata), 0);
        rst = 1'b0;

        // R1: reset levels 4 and enables 0
        tag = "R1";
        for (int a = 0; a < 20; a++) rd(a);
        rd(0);
        irq_req = '1;
        idle(3);
        irq_req = '0;

        // R3: enables, reserved and padding bits
        tag = "R3";
        for (int a = 16; a < 20; a++) wr(a, 16'hFFFF);
        for (int a = 16; a < 20; a++) rd(a);
        rd(0);

        // R2: pad bits and padding nibbles
        tag = "R2";
        wr(2, 16'hFFFF);
        rd(2);
        wr(2, 16'h8888);
        rd(2);
        wr(13, 16'hFFFF);
        rd(13);
        wr(2, 16'h5A3C);
        rd(2);
        rd(0);

        // R4: read-before-write ordering and unmapped words
        tag = "R4";
        wr(3, 16'h1234);
        rd(3);
        for (int a = 14; a < 32; a++) if (a < 16 || a >= 20) rd(a);
        wr(15, 16'hFFFF);
        rd(15);

        // R9 / R11: single requests across the range, one-cycle latency
        tag = "R11";
        for (int a = 0; a < 14; a++) wr(a, 16'h3333);
        for (int i = 0; i < 54; i += 5) begin
            irq_req = '0;
            irq_req[i] = 1'b1;
            rd(0);
        end
        irq_req = '0;
        idle(2);

        // R7: distinct levels, highest level wins
        tag = "R7";
        wr(0, 16'h0121);
        wr(5, 16'h0600);
        wr(10, 16'h7000);
        irq_req = '0;
        irq_req[0] = 1'b1; irq_req[1] = 1'b1; irq_req[22] = 1'b1; irq_req[43] = 1'b1;
        idle(2);
        irq_req[43] = 1'b0;
        idle(2);
        irq_req[22] = 1'b0;
        idle(2);
        // source 0 at level 1 against source 20 at level 7
        wr(0, 16'h3331);
        wr(5, 16'h3337);
        irq_req = '0;
        irq_req[0] = 1'b1; irq_req[20] = 1'b1;
        idle(2);

        // R8: equal levels, lowest index wins
        tag = "R8";
        for (int a = 0; a < 14; a++) wr(a, 16'h5555);
        irq_req = '0;
        irq_req[40] = 1'b1; irq_req[17] = 1'b1; irq_req[33] = 1'b1;
        idle(2);
        irq_req[17] = 1'b0;
        idle(2);
        irq_req = 54'h0F0F_0F0F_0F0F_0;
        idle(2);

        // R5: level-0 sources never win
        tag = "R5";
        wr(1, 16'h0000);
        irq_req = '0;
        irq_req[4] = 1'b1; irq_req[5] = 1'b1; irq_req[7] = 1'b1;
        idle(2);
        irq_req[30] = 1'b1;
        idle(2);

        // R6: threshold sweep
        tag = "R6";
        wr(2, 16'h7362);
        irq_req = '0;
        irq_req[8] = 1'b1; irq_req[9] = 1'b1; irq_req[10] = 1'b1; irq_req[11] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            cur_lvl = c[2:0];
            idle(1);
        end
        cur_lvl = '0;

        // R10: reserved positions at top level
        tag = "R10";
        for (int a = 10; a < 14; a++) wr(a, 16'h7777);
        irq_req = '0;
        irq_req[41] = 1'b1;
        for (int i = 45; i < 54; i++) irq_req[i] = 1'b1;
        idle(2);
        irq_req[42] = 1'b1;
        idle(2);
        irq_req[42] = 1'b0;
        irq_req[44] = 1'b1;
        idle(2);

        // R11: no eligible request clears the fields
        tag = "R11";
        irq_req = '0;
        idle(2);

        // Random mix against the model
        tag = "R7/R8";
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 9));
            logic [63:0] pat = {$urandom, $urandom};
            if (r < 3) pat = pat & {$urandom, $urandom};
            irq_req = pat[53:0];
            cur_lvl = (r == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 2));
            if (r == 9)
                wr(int'($urandom_range(0, 13)), int'($urandom_range(0, 65535)));
            else if (r == 8)
                wr(int'($urandom_range(16, 19)), int'($urandom_range(0, 65535)));
            else
                rd(int'($urandom_range(0, 31)));
        end

        irq_req = '0;
        cur_lvl = '0;
        idle(2);
        finish_run();
    end

endmodule